// File: doc/BRIEF.md
# Instruction Issue Cycle Estimator

This block walks a stream of decoded instruction descriptors and works out the cycle at which each one would issue on a single in-order wavefront. Each descriptor gives a byte address, whether the instruction is one or two dwords long, a base latency, a class code and an end-of-program marker. The block adds an alignment penalty to some two-dword instructions and a stall before a scalar ALU operation that follows a mask-writing vector operation too closely. It does not execute anything.

Code is treated as 32-byte fetch blocks of eight dword slots, and a slot is taken from address bits [4:2]. For each accepted descriptor the block gives an issue timestamp on a registered output. The descriptor marked last also produces a done flag and the program's total cycle count. After that the history is cleared, so the next descriptor starts a fresh program. The output slot holds one result, and a new descriptor is taken only when that slot is free or is being drained in the same cycle.

Top module: `iss_est`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. The first descriptor after reset, and the first one after a last descriptor, issues at cycle 0 with no penalty or stall.
- R2: Each later descriptor issues at the previous issue cycle plus the previous effective latency, plus any penalty, raised to the hazard bound if one applies. The effective latency is in_lat, and a latency field of 0 means 4.
- R3: Class code 3 (exec-mask save) has an effective latency of 8 whatever in_lat holds. It also counts as a scalar ALU operation under R8.
- R4: A one-dword descriptor (in_two_dw=0) never takes an alignment penalty. A two-dword descriptor whose slot is 0, 1 or 2 takes no penalty either.
- R5: A two-dword descriptor at slot 3 or above takes a 4-cycle penalty unless R6 or R7 exempts it.
- R6: When the previous effective latency L is above 4, a slot s with s + floor(L/4) >= 8 is exempt.
- R7: When the previous descriptor was two-dword with an effective latency of at least 16, and (addr>>2) minus the previous (addr>>2) is between 2 and 5 inclusive (modulo the address width), the current descriptor is exempt.
- R8: A scalar ALU descriptor (class 2 or 3) issues no earlier than 16 cycles after the most recent class 1 descriptor (vector op writing the condition mask) of the same program.
- R9: A descriptor whose addr[1:0] is not 0 sets out_err with its result, and its slot is taken as 0.
- R10: Issue cycles and totals saturate at 2^CNT_W-1 instead of wrapping.
- R11: in_ready equals (!out_valid || out_ready). While out_valid=1 and out_ready=0, the output fields hold steady. Class 0 is "other".
- R12: The result of a descriptor marked last has out_done=1 and out_total = its issue cycle plus its effective latency, saturated. For any other descriptor, out_done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor will be taken this cycle |
| in_addr | input | ADDR_W | Byte address of the instruction |
| in_two_dw | input | 1 | 1 = two-dword instruction |
| in_lat | input | LAT_W | Base latency in cycles (0 means 4) |
| in_cls | input | 2 | 0 other, 1 mask-writing vector, 2 scalar ALU, 3 exec-mask save |
| in_last | input | 1 | Final instruction of the program |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_issue | output | CNT_W | Issue cycle of the descriptor |
| out_err | output | 1 | Misaligned address seen |
| out_done | output | 1 | Result belongs to the last descriptor |
| out_total | output | CNT_W | Total program cycles, valid with out_done |

## Verification
Any corruption in the stored previous-instruction state, such as its latency, its width flag or its dword index, shows up as a wrong out_issue on the very next result, because every timestamp builds on the one before it. A stale mask-writer timestamp shows up as a missing or spurious stall on the first scalar descriptor that follows. History that is not cleared after a last descriptor shows up as a nonzero issue on the next program's first result. The bench compares every result against a reference model as soon as the result appears, so a fault is reported within one descriptor of the point where it takes effect.

// File: rtl/iss_pkg.sv
// Shared class codes and fixed timing constants for the issue estimator.
package iss_pkg;
    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_VMASK = 2'd1,
        CLS_SALU  = 2'd2,
        CLS_SAVEX = 2'd3
    } iss_cls_e;

    localparam int DEF_LAT   = 4;   // latency when the field is zero
    localparam int SAVEX_LAT = 8;   // exec-mask save latency
    localparam int SLOTS     = 8;   // dword slots per 32-byte block
    localparam int FREE_LO   = 3;   // slots below this never pay
endpackage

// File: rtl/iss_align.sv
// Alignment penalty decision for one descriptor.
// Assumes: prev_lat is already the effective latency of the previous
// descriptor; slot is already forced to 0 for a misaligned address.
module iss_align #(
    parameter int ADDR_W = 32,
    parameter int LAT_W  = 8,
    parameter int NEAR_LAT = 16
) (
    input  logic              two_dw,
    input  logic [2:0]        slot,
    input  logic              have_prev,
    input  logic [LAT_W-1:0]  prev_lat,
    input  logic              prev_two,
    input  logic [ADDR_W-3:0] dw_diff,
    output logic              pen
);
    import iss_pkg::*;

    logic late_free;
    logic near_free;

    // Exemptions granted by the previous instruction's latency.
    always_comb begin
        late_free = (prev_lat > LAT_W'(DEF_LAT)) &&
                    ((LAT_W'(slot) + (prev_lat >> 2)) >= LAT_W'(SLOTS));
        near_free = prev_two && (prev_lat >= LAT_W'(NEAR_LAT)) &&
                    (dw_diff >= (ADDR_W-2)'(2)) && (dw_diff <= (ADDR_W-2)'(5));
    end

    // Final penalty flag.
    always_comb begin
        pen = two_dw && have_prev && (slot >= 3'(FREE_LO)) && !late_free && !near_free;
    end
endmodule

// File: rtl/iss_hazard.sv
// Raises a scalar ALU issue time to the mask-write hazard bound.
// Assumes: vm_time is the issue time of the latest mask-writing vector op.
module iss_hazard #(
    parameter int CNT_W = 32,
    parameter int GAP   = 16
) (
    input  logic [CNT_W-1:0] base,
    input  logic             is_scalar,
    input  logic             vm_seen,
    input  logic [CNT_W-1:0] vm_time,
    output logic [CNT_W-1:0] issue
);
    localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0]   need_w;
    logic [CNT_W-1:0] need;

    // Saturating earliest legal scalar issue time.
    always_comb begin
        need_w = {1'b0, vm_time} + (CNT_W+1)'(GAP);
        need   = (need_w > MAXV) ? {CNT_W{1'b1}} : need_w[CNT_W-1:0];
        issue  = (is_scalar && vm_seen && base < need) ? need : base;
    end
endmodule

// File: rtl/iss_est.sv
// Instruction issue cycle estimator top.
// Takes one descriptor per handshake, computes its issue cycle from the
// previous instruction's state, and holds the result in a one-entry
// output register. Assumes descriptors arrive in program order.
module iss_est #(
    parameter int CNT_W    = 32,
    parameter int ADDR_W   = 32,
    parameter int LAT_W    = 8,
    parameter int HAZ_GAP  = 16,
    parameter int PEN_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_two_dw,
    input  logic [LAT_W-1:0]  in_lat,
    input  logic [1:0]        in_cls,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CNT_W-1:0]  out_issue,
    output logic              out_err,
    output logic              out_done,
    output logic [CNT_W-1:0]  out_total
);
    import iss_pkg::*;

    localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

    // previous-instruction state
    logic              have_prev;
    logic [CNT_W-1:0]  prev_issue;
    logic [LAT_W-1:0]  prev_lat;
    logic              prev_two;
    logic [ADDR_W-3:0] prev_dw;
    logic              vm_seen;
    logic [CNT_W-1:0]  vm_time;

    logic              accept;
    logic              misal;
    logic [2:0]        slot;
    logic [LAT_W-1:0]  eff_lat;
    logic [ADDR_W-3:0] dw_diff;
    logic              pen;
    logic              is_scalar;
    logic [CNT_W:0]    base_w;
    logic [CNT_W-1:0]  base;
    logic [CNT_W:0]    pre_w;
    logic [CNT_W-1:0]  pre;
    logic [CNT_W-1:0]  issue_nx;
    logic [CNT_W:0]    tot_w;
    logic [CNT_W-1:0]  total_nx;

    // Handshake: accept when the output slot is free or draining.
    always_comb begin
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
    end

    // Decode of the incoming descriptor.
    always_comb begin
        misal     = (in_addr[1:0] != 2'b00);
        slot      = misal ? 3'd0 : in_addr[4:2];
        dw_diff   = in_addr[ADDR_W-1:2] - prev_dw;
        is_scalar = (in_cls == CLS_SALU) || (in_cls == CLS_SAVEX);
        if (in_cls == CLS_SAVEX)
            eff_lat = LAT_W'(SAVEX_LAT);
        else if (in_lat == '0)
            eff_lat = LAT_W'(DEF_LAT);
        else
            eff_lat = in_lat;
    end

    iss_align #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) align_i (
        .two_dw   (in_two_dw),
        .slot     (slot),
        .have_prev(have_prev),
        .prev_lat (prev_lat),
        .prev_two (prev_two),
        .dw_diff  (dw_diff),
        .pen      (pen)
    );

    // Saturating base time and penalty addition.
    always_comb begin
        base_w = {1'b0, prev_issue} + (CNT_W+1)'(prev_lat);
        if (!have_prev)
            base = '0;
        else
            base = (base_w > MAXV) ? {CNT_W{1'b1}} : base_w[CNT_W-1:0];
        pre_w = {1'b0, base} + (pen ? (CNT_W+1)'(PEN_CYC) : '0);
        pre   = (pre_w > MAXV) ? {CNT_W{1'b1}} : pre_w[CNT_W-1:0];
    end

    iss_hazard #(.CNT_W(CNT_W), .GAP(HAZ_GAP)) haz_i (
        .base     (pre),
        .is_scalar(is_scalar),
        .vm_seen  (vm_seen),
        .vm_time  (vm_time),
        .issue    (issue_nx)
    );

    // Saturating program total for a last descriptor.
    always_comb begin
        tot_w    = {1'b0, issue_nx} + (CNT_W+1)'(eff_lat);
        total_nx = (tot_w > MAXV) ? {CNT_W{1'b1}} : tot_w[CNT_W-1:0];
    end

    // History registers: update on accept, clear after a last descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n || (accept && in_last)) begin
            have_prev  <= 1'b0;
            prev_issue <= '0;
            prev_lat   <= '0;
            prev_two   <= 1'b0;
            prev_dw    <= '0;
            vm_seen    <= 1'b0;
            vm_time    <= '0;
        end else if (accept) begin
            have_prev  <= 1'b1;
            prev_issue <= issue_nx;
            prev_lat   <= eff_lat;
            prev_two   <= in_two_dw;
            prev_dw    <= in_addr[ADDR_W-1:2];
            if (in_cls == CLS_VMASK) begin
                vm_seen <= 1'b1;
                vm_time <= issue_nx;
            end
        end
    end

    // One-entry output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_issue <= '0;
            out_err   <= 1'b0;
            out_done  <= 1'b0;
            out_total <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_issue <= issue_nx;
            out_err   <= misal;
            out_done  <= in_last;
            out_total <= in_last ? total_nx : '0;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_issue) && $stable(out_done));
    // R1
    first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !have_prev |=> out_issue == '0);
    // R2
    monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && have_prev |-> issue_nx >= prev_issue);
    // R4
    single_no_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !in_two_dw |-> !pen);
    // R8
    haz_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && is_scalar && vm_seen |->
        ({1'b0, issue_nx} >= {1'b0, vm_time} + (CNT_W+1)'(HAZ_GAP)) || (issue_nx == {CNT_W{1'b1}}));
    // R12
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_valid || $past(out_valid));
endmodule

// File: tb/iss_est_tb.sv
// Bench for iss_est: directed corners plus seeded random stream,
// checked against a reference model written from the requirements.
module iss_est_tb_top;
    localparam int CW = 12;
    localparam longint MAXC = (64'd1 << CW) - 1;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic        in_ready;
    logic [31:0] in_addr = 0;
    logic        in_two_dw = 0;
    logic [7:0]  in_lat = 0;
    logic [1:0]  in_cls = 0;
    logic        in_last = 0;
    logic        out_valid;
    logic        out_ready = 1;
    logic [CW-1:0] out_issue;
    logic        out_err;
    logic        out_done;
    logic [CW-1:0] out_total;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    iss_est #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_two_dw(in_two_dw), .in_lat(in_lat),
        .in_cls(in_cls), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_issue(out_issue), .out_err(out_err),
        .out_done(out_done), .out_total(out_total)
    );

    // reference model state
    bit     m_have = 0;
    longint m_issue = 0;
    longint m_lat = 0;
    bit     m_two = 0;
    longint m_dw = 0;
    bit     m_vm = 0;
    longint m_vmt = 0;

    function automatic longint sat(input longint v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    function automatic longint eff_lat_f(input int lat, input int cls);
        if (cls == 3) return 8;
        if (lat == 0) return 4;
        return lat;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input bit two, input int lat,
                        input int cls, input bit last, input string tag);
        longint el, slot, diff, base, iss, tot;
        bit pen, lfree, nfree, mis;
        mis  = (a[1:0] != 0);
        slot = mis ? 0 : a[4:2];
        el   = eff_lat_f(lat, cls);
        diff = (longint'(a >> 2) - m_dw) & 64'h3FFF_FFFF;
        if (!m_have) begin
            iss = 0;
        end else begin
            base  = sat(m_issue + m_lat);
            lfree = (m_lat > 4) && (slot + m_lat / 4 >= 8);
            nfree = m_two && m_lat >= 16 && diff >= 2 && diff <= 5;
            pen   = two && slot >= 3 && !lfree && !nfree;
            iss   = sat(base + (pen ? 4 : 0));
            if ((cls == 2 || cls == 3) && m_vm && iss < sat(m_vmt + 16))
                iss = sat(m_vmt + 16);
        end
        tot = sat(iss + el);
        if (last) begin
            m_have = 0; m_vm = 0; m_dw = 0;
        end else begin
            m_have = 1; m_issue = iss; m_lat = el; m_two = two;
            m_dw = longint'(a >> 2);
            if (cls == 1) begin m_vm = 1; m_vmt = iss; end
        end
        @(negedge clk);
        in_addr = a; in_two_dw = two; in_lat = 8'(lat); in_cls = 2'(cls);
        in_last = last; in_valid = 1;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 0;
        chk(out_valid == 1, {tag, " out_valid"}, out_valid, 1);
        chk(out_issue == iss, {tag, " issue"}, out_issue, iss);
        chk(out_err == mis, {tag, " R9 err"}, out_err, mis);
        chk(out_done == last, {tag, " R12 done"}, out_done, last);
        if (last) chk(out_total == tot, {tag, " R12 total"}, out_total, tot);
    endtask

    // R11: hold the consumer off and observe the held result
    task automatic hold(input int n);
        logic [CW-1:0] snap;
        snap = out_issue;
        out_ready = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(in_ready == 0, "R11 in_ready low", in_ready, 0);
            chk(out_valid == 1 && out_issue == snap, "R11 hold", out_issue, snap);
        end
        out_ready = 1;
        @(posedge clk); #1;
        chk(out_valid == 0, "R11 drained", out_valid, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        int seed;
        seed = 17;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
        chk(in_ready == 1, "R1 reset in_ready", in_ready, 1);
        @(negedge clk); rst_n = 1;

        // R1 first issue at 0 despite slot 5
        send(32'h14, 1, 4, 0, 0, "R1");
        // R2 latency 0 means 4; R4 slot1 two-dword free
        send(32'h20, 0, 0, 0, 0, "R2");
        send(32'h24, 1, 4, 0, 0, "R4");
        // R5 slot 3 two-dword after lat 4
        send(32'h2C, 1, 4, 0, 0, "R5");
        // R6: prev lat 12 frees slot 5, not slot 4
        send(32'h40, 0, 12, 0, 0, "R6");
        send(32'h54, 1, 12, 0, 0, "R6 free");
        send(32'h60, 0, 12, 0, 0, "R6");
        send(32'h70, 1, 4, 0, 0, "R6 pen");
        // R7: prev two-dword lat 16, diff 3 at slot 3
        send(32'h80, 1, 16, 0, 0, "R7");
        send(32'h8C, 1, 4, 0, 0, "R7 free");
        // R7 negative: prev single-dword
        send(32'hA4, 0, 16, 0, 0, "R7");
        send(32'hAC, 1, 4, 0, 0, "R7 pen");
        // R8 hazard: mask writer then scalar ALU; class 0 not stalled
        send(32'hC0, 0, 4, 1, 0, "R8");
        send(32'hC4, 0, 4, 0, 0, "R8 other");
        send(32'hC8, 0, 4, 2, 0, "R8 stall");
        // R3 exec save latency 8
        send(32'hCC, 0, 4, 3, 0, "R3");
        send(32'hD0, 0, 4, 0, 0, "R3 next");
        // R9 misaligned two-dword would be slot 3
        send(32'hEE, 1, 4, 0, 0, "R9");
        send(32'hF4, 0, 4, 0, 1, "R12");
        hold(3);
        send(32'h100, 0, 4, 0, 0, "R1 restart");
        // R10 saturation
        for (int i = 0; i < 20; i++)
            send(32'h200 + 4 * i, 0, 255, 0, 0, "R10");
        send(32'h300, 0, 255, 0, 1, "R10 total");

        // random stream
        a = 32'h1000;
        for (int i = 0; i < 400; i++) begin
            bit two; int lat, cls; bit last;
            two  = $urandom_range(0, 1);
            lat  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 40) : 4 * $urandom_range(1, 6);
            cls  = $urandom_range(0, 3);
            last = ($urandom_range(0, 12) == 0);
            if ($urandom_range(0, 15) == 0) a = a + 32'($urandom_range(1, 3));
            else if ($urandom_range(0, 10) == 0) a = {a[31:2] + 30'($urandom_range(0, 20)), 2'b00};
            send(a, two, lat, cls, last, "R2 random");
            if ($urandom_range(0, 9) == 0) hold($urandom_range(1, 4));
            a = {a[31:2], 2'b00} + (two ? 32'd8 : 32'd4);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule